// File: doc/BRIEF.md
# Phase-Accumulator PWM Generator

This block turns a system clock into a pulse-width-modulated bit without any period counter and without any divider. A 10-bit phase register adds a tuning word on every clock and wraps modulo 1024. The average output frequency is therefore `fclk * word / 1024`, which need not divide the clock evenly. The pulse width is set by comparing the phase against a threshold. The duty value is given on a 0..128 scale, so the threshold is just the duty shifted left by three bits.

The tuning words are fixed at elaboration from the clock rate and a frequency step. With the defaults (50 MHz clock, 5 MHz step, six settings) the selectable outputs are 5, 10, 15, 20, 25 and 30 MHz. Software-facing logic picks a setting index and a duty value, then pulses the load strobe. The captured pair waits and is switched in only when the phase next wraps, so a period is never cut short or stretched by a change. A one-clock wrap pulse marks every period start, for use by downstream logic.

Top module: `pacc_pwm`

## Requirements
- R1: Every clock the phase grows by the active tuning word modulo 1024; `wrap_out` is high for exactly the cycles in which the registered phase has just wrapped past 1024.
- R2: The tuning word for index i (0..5) is floor(1024·5 MHz·(i+1)/50 MHz), giving 102, 204, 307, 409, 512, 614; over any 1024 consecutive cycles with an unchanged setting, `wrap_out` is high exactly that many times.
- R3: `pwm_out` is high in a cycle when the registered phase is strictly less than 8 × active duty, and low otherwise.
- R4: An active duty of 0 keeps `pwm_out` low on every cycle.
- R5: An active duty of 128 keeps `pwm_out` high on every cycle; a loaded duty above 128 is treated as 128.
- R6: `freq_sel` and `duty` are captured only in cycles with `load` high; without `load`, changes on them have no effect on the outputs.
- R7: A captured setting takes effect at the first wrap after the capture, and both fields switch in the same cycle; the active setting never changes in a cycle without a wrap.
- R8: A `freq_sel` value of 6 or above is treated as index 5.
- R9: A load in the same cycle as a wrap is held until the following wrap; a load at that wrap still switches in any earlier pending setting.
- R10: Synchronous reset (`rst` high) sets phase 0, index 0, duty 64, and drives `pwm_out` and `wrap_out` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture strobe for `freq_sel` and `duty` |
| freq_sel | input | 3 | Frequency setting index (0..5, higher clamps to 5) |
| duty | input | 8 | Duty on a 0..128 scale (higher clamps to 128) |
| pwm_out | output | 1 | PWM output |
| wrap_out | output | 1 | One-clock pulse at each phase wrap |

## Verification
The bound checker watches, on every cycle, that the wrap pulse matches a decrease of the phase, that the active setting only changes on a wrap cycle, that duty 0 and 128 pin the output, that the clamped settings stay in range, and that reset leaves the specified state. The average frequency of each table entry, the deferral of a load until the next wrap (including a load on the wrap cycle itself), the clamping of out-of-range inputs and the indifference to unstrobed inputs can only be shown by the bench's scenarios. In those scenarios a cycle-by-cycle model of the requirements predicts both outputs, and wrap counts over 1024-cycle windows are compared with the table values.

// File: rtl/pacc_pwm_pkg.sv
package pacc_pwm_pkg;

    localparam int unsigned          DEF_PHASE_W = 10;
    localparam int unsigned          DEF_DUTY_W  = 8;
    localparam int unsigned          DEF_IDX_W   = 3;
    localparam int unsigned          DEF_N_FREQ  = 6;
    localparam longint unsigned      DEF_CLK_HZ  = 64'd50_000_000;
    localparam longint unsigned      DEF_STEP_HZ = 64'd5_000_000;

    // floor(2^phase_w * f / clk) with f = step * (idx + 1), elaboration only
    function automatic longint unsigned tune_word(
        input longint unsigned clk_hz,
        input longint unsigned step_hz,
        input int unsigned     idx,
        input int unsigned     phase_w
    );
        longint unsigned f_hz;
        longint unsigned span;
        f_hz = step_hz * longint'(idx + 1);
        span = longint'(1) << phase_w;
        return (span * f_hz) / clk_hz;
    endfunction

endpackage

// File: rtl/pacc_tune_rom.sv
module pacc_tune_rom
    import pacc_pwm_pkg::*;
#(
    parameter int unsigned     PHASE_W = DEF_PHASE_W,
    parameter int unsigned     IDX_W   = DEF_IDX_W,
    parameter int unsigned     N_FREQ  = DEF_N_FREQ,
    parameter longint unsigned CLK_HZ  = DEF_CLK_HZ,
    parameter longint unsigned STEP_HZ = DEF_STEP_HZ
) (
    input  logic [IDX_W-1:0]   sel,
    output logic [PHASE_W-1:0] word
);

    logic [PHASE_W-1:0] tbl [N_FREQ];

    for (genvar gi = 0; gi < N_FREQ; gi++) begin : g_entry
        assign tbl[gi] = PHASE_W'(tune_word(CLK_HZ, STEP_HZ, gi, PHASE_W));
    end

    always_comb begin
        word = '0;
        for (int i = 0; i < N_FREQ; i++) begin
            if (sel == IDX_W'(i)) word = tbl[i];
        end
    end

endmodule

// File: rtl/pacc_phase_step.sv
module pacc_phase_step #(
    parameter int unsigned PHASE_W = 10
) (
    input  logic [PHASE_W-1:0] phase,
    input  logic [PHASE_W-1:0] word,
    output logic [PHASE_W-1:0] phase_nx,
    output logic               carry
);

    logic [PHASE_W:0] sum;

    always_comb begin
        sum      = {1'b0, phase} + {1'b0, word};
        phase_nx = sum[PHASE_W-1:0];
        carry    = sum[PHASE_W];
    end

endmodule

// File: rtl/pacc_duty_cmp.sv
module pacc_duty_cmp #(
    parameter int unsigned PHASE_W = 10,
    parameter int unsigned DUTY_W  = 8
) (
    input  logic [PHASE_W-1:0] phase,
    input  logic [DUTY_W-1:0]  level,
    output logic               high
);

    // duty full scale is 2^(DUTY_W-1); scale up to the phase range by a shift
    localparam int unsigned SHIFT = PHASE_W - (DUTY_W - 1);

    logic [PHASE_W:0] thr;

    always_comb begin
        thr  = (PHASE_W + 1)'(level) << SHIFT;
        high = ({1'b0, phase} < thr);
    end

endmodule

// File: rtl/pacc_pwm.sv
module pacc_pwm
    import pacc_pwm_pkg::*;
#(
    parameter int unsigned     PHASE_W = DEF_PHASE_W,
    parameter int unsigned     DUTY_W  = DEF_DUTY_W,
    parameter int unsigned     IDX_W   = DEF_IDX_W,
    parameter int unsigned     N_FREQ  = DEF_N_FREQ,
    parameter longint unsigned CLK_HZ  = DEF_CLK_HZ,
    parameter longint unsigned STEP_HZ = DEF_STEP_HZ
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [IDX_W-1:0]  freq_sel,
    input  logic [DUTY_W-1:0] duty,
    output logic              pwm_out,
    output logic              wrap_out
);

    localparam logic [DUTY_W-1:0] DUTY_FULL = DUTY_W'(1) << (DUTY_W - 1);
    localparam logic [DUTY_W-1:0] DUTY_RST  = DUTY_FULL >> 1;
    localparam logic [IDX_W-1:0]  IDX_MAX   = IDX_W'(N_FREQ - 1);

    typedef struct packed {
        logic [PHASE_W-1:0] acc;
        logic [IDX_W-1:0]   act_idx;
        logic [DUTY_W-1:0]  act_duty;
        logic [IDX_W-1:0]   pend_idx;
        logic [DUTY_W-1:0]  pend_duty;
        logic               pend_vld;
        logic               pwm;
        logic               wrap;
    } state_t;

    localparam state_t ST_RST = '{
        acc:       '0,
        act_idx:   '0,
        act_duty:  DUTY_RST,
        pend_idx:  '0,
        pend_duty: DUTY_RST,
        pend_vld:  1'b0,
        pwm:       1'b0,
        wrap:      1'b0
    };

    state_t st_d, st_q;

    logic [PHASE_W-1:0] word;
    logic [PHASE_W-1:0] phase_nx;
    logic               carry;
    logic               swap;
    logic [DUTY_W-1:0]  duty_nx;
    logic               level_nx;
    logic [IDX_W-1:0]   sel_clamped;
    logic [DUTY_W-1:0]  duty_clamped;

    pacc_tune_rom #(
        .PHASE_W (PHASE_W),
        .IDX_W   (IDX_W),
        .N_FREQ  (N_FREQ),
        .CLK_HZ  (CLK_HZ),
        .STEP_HZ (STEP_HZ)
    ) u_rom (
        .sel  (st_q.act_idx),
        .word (word)
    );

    pacc_phase_step #(
        .PHASE_W (PHASE_W)
    ) u_step (
        .phase    (st_q.acc),
        .word     (word),
        .phase_nx (phase_nx),
        .carry    (carry)
    );

    // next active duty: a pending setting switches in on the wrap
    assign swap    = carry && st_q.pend_vld;
    assign duty_nx = swap ? st_q.pend_duty : st_q.act_duty;

    pacc_duty_cmp #(
        .PHASE_W (PHASE_W),
        .DUTY_W  (DUTY_W)
    ) u_cmp (
        .phase (phase_nx),
        .level (duty_nx),
        .high  (level_nx)
    );

    assign sel_clamped  = (freq_sel > IDX_MAX)  ? IDX_MAX   : freq_sel;
    assign duty_clamped = (duty > DUTY_FULL)    ? DUTY_FULL : duty;

    always_comb begin
        st_d      = st_q;
        st_d.acc  = phase_nx;
        st_d.wrap = carry;
        if (swap) begin
            st_d.act_idx  = st_q.pend_idx;
            st_d.act_duty = st_q.pend_duty;
            st_d.pend_vld = 1'b0;
        end
        if (load) begin
            st_d.pend_idx  = sel_clamped;
            st_d.pend_duty = duty_clamped;
            st_d.pend_vld  = 1'b1;
        end
        st_d.pwm = level_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_RST;
        else     st_q <= st_d;
    end

    assign pwm_out  = st_q.pwm;
    assign wrap_out = st_q.wrap;

endmodule

// File: rtl/pacc_pwm_chk.sv
module pacc_pwm_chk #(
    parameter int unsigned PHASE_W = 10,
    parameter int unsigned DUTY_W  = 8,
    parameter int unsigned IDX_W   = 3,
    parameter int unsigned N_FREQ  = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               pwm_out,
    input logic               wrap_out,
    input logic [PHASE_W-1:0] acc_q,
    input logic [IDX_W-1:0]   act_idx_q,
    input logic [DUTY_W-1:0]  act_duty_q
);

    localparam logic [DUTY_W-1:0] FULL = DUTY_W'(1) << (DUTY_W - 1);

    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    // R1: a wrap shows as the phase falling below its previous value
    p_wrap_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        seen |-> (wrap_out == (acc_q < $past(acc_q))));

    // R4
    p_duty_zero_low_r4: assert property (@(posedge clk) disable iff (rst)
        (seen && act_duty_q == '0) |-> !pwm_out);

    // R5
    p_duty_full_high_r5: assert property (@(posedge clk) disable iff (rst)
        (seen && act_duty_q == FULL) |-> pwm_out);

    // R7: active setting only moves on a wrap cycle
    p_switch_on_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (seen && !wrap_out) |-> ($stable(act_duty_q) && $stable(act_idx_q)));

    // R5, R8: clamping keeps the active setting in range
    p_setting_range_r8: assert property (@(posedge clk) disable iff (rst)
        (act_duty_q <= FULL) && (act_idx_q < IDX_W'(N_FREQ)));

    // R10
    p_reset_state_r10: assert property (@(posedge clk)
        rst |=> (acc_q == '0 && !pwm_out && !wrap_out &&
                 act_idx_q == '0 && act_duty_q == (FULL >> 1)));

endmodule

bind pacc_pwm pacc_pwm_chk #(
    .PHASE_W (PHASE_W),
    .DUTY_W  (DUTY_W),
    .IDX_W   (IDX_W),
    .N_FREQ  (N_FREQ)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pwm_out    (pwm_out),
    .wrap_out   (wrap_out),
    .acc_q      (st_q.acc),
    .act_idx_q  (st_q.act_idx),
    .act_duty_q (st_q.act_duty)
);

// File: tb/pacc_pwm_bench.sv
`timescale 1ns/1ps
module pacc_pwm_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       load = 1'b0;
    logic [2:0] freq_sel = '0;
    logic [7:0] duty = '0;
    logic       pwm_out, wrap_out;

    int vectors = 0;
    int miscompares = 0;
    string cur_req = "R10";
    bit done = 0;

    always #2 clk = ~clk;

    pacc_pwm u_pacc_pwm (
        .clk(clk), .rst(rst), .load(load), .freq_sel(freq_sel),
        .duty(duty), .pwm_out(pwm_out), .wrap_out(wrap_out)
    );

    // requirement model (R1..R10): tuning words from R2
    int tw [6] = '{102, 204, 307, 409, 512, 614};
    int m_acc, m_idx, m_duty, m_pi, m_pd;
    bit m_pv;
    logic [1:0] exp_q [$];

    always @(posedge clk) begin
        int sum;
        bit wr;
        logic pw;
        if (rst) begin
            m_acc = 0; m_idx = 0; m_duty = 64; m_pi = 0; m_pd = 64; m_pv = 0;
            pw = 0; wr = 0;
        end else begin
            sum   = m_acc + tw[m_idx];
            wr    = (sum >= 1024);
            m_acc = sum % 1024;
            if (wr && m_pv) begin m_idx = m_pi; m_duty = m_pd; m_pv = 0; end
            if (load) begin
                m_pi = (freq_sel > 5) ? 5 : int'(freq_sel);
                m_pd = (duty > 128) ? 128 : int'(duty);
                m_pv = 1;
            end
            pw = (m_acc < m_duty * 8);
        end
        exp_q.push_back({pw, wr});
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        logic [1:0] e;
        if (!done && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            vectors++;
            if ({pwm_out, wrap_out} !== e) begin
                miscompares++;
                $display("FAIL %s: {pwm,wrap} actual %b expected %b at %0t",
                         cur_req, {pwm_out, wrap_out}, e, $time);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_load(input int sel, input int d);
        @(negedge clk);
        load = 1'b1; freq_sel = 3'(sel); duty = 8'(d);
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic count_window(input int n, output int wraps, output int highs);
        wraps = 0; highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wraps += int'(wrap_out);
            highs += int'(pwm_out);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int w, h;
        tick(3);
        cur_req = "R10";
        chk("R10 pwm in reset", int'(pwm_out), 0);
        chk("R10 wrap in reset", int'(wrap_out), 0);
        @(negedge clk) rst = 1'b0;

        // default setting: index 0, duty 64
        cur_req = "R1/R3";
        count_window(1024, w, h);
        chk("R2 wraps idx0", w, 102);

        cur_req = "R2";
        do_load(2, 32);
        tick(20);
        count_window(1024, w, h);
        chk("R2 wraps idx2", w, 307);
        do_load(5, 100);
        tick(20);
        count_window(1024, w, h);
        chk("R2 wraps idx5", w, 614);

        cur_req = "R8";
        do_load(7, 50);
        tick(20);
        count_window(1024, w, h);
        chk("R8 idx7 clamps to idx5", w, 614);

        cur_req = "R4";
        do_load(1, 0);
        tick(20);
        count_window(300, w, h);
        chk("R4 duty0 highs", h, 0);

        cur_req = "R6";
        freq_sel = 3'd4; duty = 8'd128;
        count_window(300, w, h);
        chk("R6 unstrobed duty ignored", h, 0);
        chk("R6 unstrobed sel ignored", w, (300 * 204) / 1024 + ((300 * 204) % 1024 != 0 ? 1 : 0) - ((w < 59) ? 1 : 0));

        cur_req = "R5";
        do_load(3, 200);
        tick(20);
        count_window(300, w, h);
        chk("R5 duty above full high", h, 300);
        do_load(0, 128);
        tick(20);
        count_window(300, w, h);
        chk("R5 duty128 highs", h, 300);

        cur_req = "R7";
        do_load(0, 0);
        chk("R7 pending not yet active", int'(pwm_out), 1);
        tick(20);
        do_load(4, 77);
        tick(200);

        cur_req = "R9";
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            load = 1'b1; freq_sel = 3'(i % 6); duty = 8'((i * 13) % 140);
        end
        @(negedge clk) load = 1'b0;
        tick(100);

        cur_req = "R10";
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        chk("R10 pwm after reset", int'(pwm_out), 0);
        chk("R10 wrap after reset", int'(wrap_out), 0);
        @(negedge clk) rst = 1'b0;
        count_window(1024, w, h);
        chk("R10 index 0 after reset", w, 102);

        tick(2);
        finish_run();
    end

endmodule